// File: doc/BRIEF.md
# Serial Hex Program Loader

This block sits between a UART receiver and a processor's program SRAM during bring-up. It takes the received byte stream one byte per valid strobe and reads it as lines of ASCII text. Each line carries a hexadecimal byte address followed by a hexadecimal data word. For every complete address/data pair the loader writes the word into SRAM. Anything that follows the data field on the same line is thrown away.

From reset the loader holds the processor in reset. When a line's address field reads all ones (FFFFFFFF), loading ends. The loader then releases the processor and sends a single start pulse. From that point it ignores all input until the next reset. Addresses that fall outside the 32 KB memory, or that are not word aligned, are not written. Instead they set a sticky error flag.

Top module: `hex_loader_top`

## Requirements
- R1: During and right after reset, `cpu_hold` is 1 and `start_pulse`, `mem_we` and `addr_err` are 0.
- R2: The characters 0-9, A-F and a-f are hex digits. A field's value is made of its last (at most 8) digits, right-aligned and zero-extended to 32 bits. Any earlier digits are dropped.
- R3: Fields are separated by one or more space (0x20) or tab (0x09) characters, and separators may also come before the first field. A line ends at CR (0x0D) or LF (0x0A). An empty line, or a line with only an address field, writes nothing.
- R4: A data field ends at the first character that is not a hex digit. In the clock cycle after that byte is accepted, `mem_we` is 1 for exactly one cycle, with `mem_addr` = address bits 14:2 and `mem_wdata` = the data value.
- R5: Characters after the data field, up to the end of the line, are ignored, including any further fields. A line whose first character that is not a separator is also not a hex digit is ignored completely.
- R6: An address of 0x8000 or above, or one whose bits 1:0 are not 00, causes no write. It sets `addr_err` in the cycle after the data field ends, and `addr_err` stays 1 until reset.
- R7: An address field equal to FFFFFFFF, ended by any character that is not a hex digit, gives a one-cycle `start_pulse` in the next cycle. `cpu_hold` falls in that same cycle, and nothing is written for that line.
- R8: After the start pulse, all input is ignored until reset: no writes, no further start pulses, and `cpu_hold` stays 0.
- R9: A byte presented while `rx_valid` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte strobe, one cycle per byte |
| rx_byte | input | 8 | Received ASCII byte |
| mem_we | output | 1 | SRAM write strobe, one cycle |
| mem_addr | output | 13 | SRAM word address |
| mem_wdata | output | 32 | SRAM write data |
| start_pulse | output | 1 | One-cycle pulse that starts the processor |
| cpu_hold | output | 1 | Holds the processor in reset while 1 |
| addr_err | output | 1 | Sticky flag for a rejected address |

## Verification
The bench checks several field layouts:
- Fields longer than eight digits, shorter than eight digits, and in mixed case. A design that shifted the wrong way, or kept the leading digits, would store the wrong word.
- Lines with leading blanks, tabs, CR LF endings and trailing extra fields. Here a careless parser would either write a second word or lose the line.

The bench also covers these cases:
- Address-only lines, empty lines, and lines that start with junk. All of these must write nothing.
- Misaligned and out-of-range addresses. These must set the sticky flag rather than wrap into memory.
- The all-ones address, ended both by a blank and by CR. A design that treated it as an ordinary address, or that kept listening afterwards, would write past the terminator or pulse start twice.

// File: rtl/hexld_pkg.sv
package hexld_pkg;
  typedef enum logic [1:0] {
    CC_HEX,
    CC_SEP,
    CC_EOL,
    CC_OTHER
  } char_cls_e;

  typedef enum logic [2:0] {
    ST_LINE,
    ST_ADDR,
    ST_GAP,
    ST_DATA,
    ST_SKIP,
    ST_DONE
  } ld_state_e;

  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_TAB   = 8'h09;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;
endpackage

// File: rtl/hex_char_class.sv
module hex_char_class
  import hexld_pkg::*;
(
  input  logic [7:0] ch,
  output char_cls_e  cls,
  output logic [3:0] nib
);
  always_comb begin
    cls = CC_OTHER;
    nib = 4'h0;
    if (ch >= 8'h30 && ch <= 8'h39) begin
      cls = CC_HEX;
      nib = ch[3:0];
    end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
      cls = CC_HEX;
      nib = ch[3:0] + 4'd9;
    end else if (ch == CH_SPACE || ch == CH_TAB) begin
      cls = CC_SEP;
    end else if (ch == CH_CR || ch == CH_LF) begin
      cls = CC_EOL;
    end
  end
endmodule

// File: rtl/hex_field_accum.sv
module hex_field_accum #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          shift,
  input  logic [3:0]    nib,
  output logic [DW-1:0] value
);
  localparam int NIBBLES = DW / 4;

  logic [NIBBLES*4-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (load) begin
      acc <= {{(NIBBLES*4-4){1'b0}}, nib};
    end else if (shift) begin
      acc <= {acc[NIBBLES*4-5:0], nib};
    end
  end

  assign value = DW'(acc);
endmodule

// File: rtl/hex_loader_fsm.sv
module hex_loader_fsm
  import hexld_pkg::*;
#(
  parameter int DW        = 32,
  parameter int MEM_BYTES = 32768,
  parameter int AW        = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  char_cls_e     cls,
  input  logic [DW-1:0] acc_val,
  output logic          acc_load,
  output logic          acc_shift,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          start_pulse,
  output logic          cpu_hold,
  output logic          addr_err
);
  localparam logic [DW-1:0] MEM_LIMIT = DW'(MEM_BYTES);

  ld_state_e     state;
  logic [DW-1:0] addr_q;
  logic          is_hex;
  logic          is_term;
  logic          addr_ok;

  assign is_hex    = (cls == CC_HEX);
  assign acc_load  = rx_valid && is_hex && (state == ST_LINE || state == ST_GAP);
  assign acc_shift = rx_valid && is_hex && (state == ST_ADDR || state == ST_DATA);
  assign is_term   = (acc_val == {DW{1'b1}});
  assign addr_ok   = (addr_q < MEM_LIMIT) && (addr_q[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_LINE;
      addr_q      <= '0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      start_pulse <= 1'b0;
      cpu_hold    <= 1'b1;
      addr_err    <= 1'b0;
    end else begin
      mem_we      <= 1'b0;
      start_pulse <= 1'b0;
      if (rx_valid) begin
        unique case (state)
          ST_LINE: begin
            if (is_hex)               state <= ST_ADDR;
            else if (cls == CC_OTHER) state <= ST_SKIP;
          end
          ST_ADDR: begin
            if (!is_hex) begin
              addr_q <= acc_val;
              if (is_term) begin
                state       <= ST_DONE;
                start_pulse <= 1'b1;
                cpu_hold    <= 1'b0;
              end else if (cls == CC_SEP) begin
                state <= ST_GAP;
              end else if (cls == CC_EOL) begin
                state <= ST_LINE;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_GAP: begin
            if (is_hex)               state <= ST_DATA;
            else if (cls == CC_EOL)   state <= ST_LINE;
            else if (cls == CC_OTHER) state <= ST_SKIP;
          end
          ST_DATA: begin
            if (!is_hex) begin
              if (addr_ok) begin
                mem_we    <= 1'b1;
                mem_addr  <= addr_q[AW+1:2];
                mem_wdata <= acc_val;
              end else begin
                addr_err <= 1'b1;
              end
              state <= (cls == CC_EOL) ? ST_LINE : ST_SKIP;
            end
          end
          ST_SKIP: begin
            if (cls == CC_EOL) state <= ST_LINE;
          end
          default: state <= ST_DONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/hex_loader_top.sv
module hex_loader_top
  import hexld_pkg::*;
#(
  parameter int DW        = 32,
  parameter int MEM_BYTES = 32768,
  parameter int AW        = $clog2(MEM_BYTES / (DW / 8))
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          start_pulse,
  output logic          cpu_hold,
  output logic          addr_err
);
  char_cls_e     cls;
  logic [3:0]    nib;
  logic          acc_load;
  logic          acc_shift;
  logic [DW-1:0] acc_val;

  hex_char_class u_class (
    .ch  (rx_byte),
    .cls (cls),
    .nib (nib)
  );

  hex_field_accum #(.DW(DW)) u_accum (
    .clk   (clk),
    .rst   (rst),
    .load  (acc_load),
    .shift (acc_shift),
    .nib   (nib),
    .value (acc_val)
  );

  hex_loader_fsm #(.DW(DW), .MEM_BYTES(MEM_BYTES), .AW(AW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .rx_valid    (rx_valid),
    .cls         (cls),
    .acc_val     (acc_val),
    .acc_load    (acc_load),
    .acc_shift   (acc_shift),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .start_pulse (start_pulse),
    .cpu_hold    (cpu_hold),
    .addr_err    (addr_err)
  );
endmodule

// File: rtl/hex_loader_chk.sv
module hex_loader_chk (
  input logic clk,
  input logic rst,
  input logic rx_valid,
  input logic mem_we,
  input logic start_pulse,
  input logic cpu_hold,
  input logic addr_err
);
  // R4
  we_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R7
  start_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);

  // R7
  hold_release_with_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_hold) |-> start_pulse);

  // R8
  no_write_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_hold |-> !mem_we);

  // R8
  hold_stays_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_hold |=> (!cpu_hold && !start_pulse));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    addr_err |=> addr_err);

  // R9
  idle_byte_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> (!mem_we && !start_pulse));
endmodule

bind hex_loader_top hex_loader_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_valid    (rx_valid),
  .mem_we      (mem_we),
  .start_pulse (start_pulse),
  .cpu_hold    (cpu_hold),
  .addr_err    (addr_err)
);

// File: tb/tb_hex_loader_top.sv
`timescale 1ns/1ps
module tb_hex_loader_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        mem_we;
  logic [12:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        start_pulse;
  logic        cpu_hold;
  logic        addr_err;

  int n_chk = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  int st_cnt = 0;
  logic [12:0] last_addr = '0;
  logic [31:0] last_data = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hex_loader_top dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .start_pulse(start_pulse), .cpu_hold(cpu_hold), .addr_err(addr_err)
  );

  always @(negedge clk) begin
    if (mem_we) begin
      wr_cnt++;
      last_addr = mem_addr;
      last_data = mem_wdata;
    end
    if (start_pulse) st_cnt++;
  end

  // vector table: line text, expected write, word address, data
  localparam int NV = 8;
  localparam logic [191:0] V_TXT [NV] = '{
    "00000010 DEADBEEF\n",
    "  0104\tcafe ; note\n",
    "7ffc 12345678 99999999\r\n",
    "\n",
    "0020\n",
    "1000000040 77\n",
    "0008 FfFf0000\n",
    "# x 0030 55\n"
  };
  localparam logic        V_WE   [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [12:0] V_ADDR [NV] = '{13'h0004, 13'h0041, 13'h1FFF, 13'h0, 13'h0, 13'h0010, 13'h0002, 13'h0};
  localparam logic [31:0] V_DATA [NV] = '{32'hDEADBEEF, 32'h0000CAFE, 32'h12345678, 32'h0, 32'h0,
                                          32'h00000077, 32'hFFFF0000, 32'h0};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_byte  = 8'h00;
  endtask

  task automatic send_line(input logic [191:0] t);
    for (int i = 23; i >= 0; i--)
      if (t[i*8 +: 8] != 8'h00) send_byte(t[i*8 +: 8]);
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int w0;
    int s0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 cpu_hold", 32'(cpu_hold), 32'd1);
    check("R1 start_pulse", 32'(start_pulse), 32'd0);
    check("R1 mem_we", 32'(mem_we), 32'd0);
    check("R1 addr_err", 32'(addr_err), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R2 R3 R4 R5 vector table
    for (int v = 0; v < NV; v++) begin
      w0 = wr_cnt;
      send_line(V_TXT[v]);
      check($sformatf("R4 vec%0d write count", v), 32'(wr_cnt - w0), 32'(V_WE[v]));
      if (V_WE[v]) begin
        check($sformatf("R2 vec%0d addr", v), 32'(last_addr), 32'(V_ADDR[v]));
        check($sformatf("R5 vec%0d data", v), last_data, V_DATA[v]);
      end
    end
    check("R6 no error on good lines", 32'(addr_err), 32'd0);
    check("R8 hold while loading", 32'(cpu_hold), 32'd1);

    // R4 strobe timing and width
    send_byte("0"); send_byte("0"); send_byte("4"); send_byte("0");
    send_byte(" "); send_byte("a"); send_byte("b"); send_byte("c");
    send_byte(" ");
    check("R4 we cycle after end", 32'(mem_we), 32'd1);
    check("R4 word addr", 32'(mem_addr), 32'h10);
    check("R4 data", mem_wdata, 32'h00000ABC);
    @(negedge clk);
    check("R4 we one cycle", 32'(mem_we), 32'd0);
    send_line("\n");

    // R9 bytes without valid ignored
    w0 = wr_cnt;
    send_byte("0"); send_byte("0"); send_byte("5"); send_byte("0"); send_byte(" ");
    rx_byte = "X";
    repeat (3) @(negedge clk);
    rx_byte = "\n";
    repeat (2) @(negedge clk);
    rx_byte = 8'h00;
    send_line("66\n");
    check("R9 one write", 32'(wr_cnt - w0), 32'd1);
    check("R9 addr", 32'(last_addr), 32'h14);
    check("R9 data", last_data, 32'h66);

    // R6 misaligned, then sticky
    w0 = wr_cnt;
    send_line("0002 11\n");
    check("R6 misaligned no write", 32'(wr_cnt - w0), 32'd0);
    check("R6 misaligned err", 32'(addr_err), 32'd1);
    send_line("0004 22\n");
    check("R6 good write after err", 32'(wr_cnt - w0), 32'd1);
    check("R6 good data", last_data, 32'h22);
    check("R6 err sticky", 32'(addr_err), 32'd1);

    // R6 out of range
    do_reset();
    check("R1 err cleared", 32'(addr_err), 32'd0);
    w0 = wr_cnt;
    send_line("8000 33\n");
    check("R6 range no write", 32'(wr_cnt - w0), 32'd0);
    check("R6 range err", 32'(addr_err), 32'd1);

    // R7 termination by blank
    do_reset();
    s0 = st_cnt;
    send_line("0010 44\n");
    for (int k = 0; k < 8; k++) send_byte("F");
    w0 = wr_cnt;
    send_byte(" ");
    check("R7 start pulse", 32'(start_pulse), 32'd1);
    check("R7 hold released", 32'(cpu_hold), 32'd0);
    @(negedge clk);
    check("R7 start one cycle", 32'(start_pulse), 32'd0);
    send_line("1234\n");
    send_line("0018 55\n");
    check("R8 no write after start", 32'(wr_cnt - w0), 32'd0);
    check("R8 single start", 32'(st_cnt - s0), 32'd1);
    check("R8 hold stays low", 32'(cpu_hold), 32'd0);

    // R7 termination by CR, lower case
    do_reset();
    check("R1 hold after reset", 32'(cpu_hold), 32'd1);
    s0 = st_cnt;
    send_line("ffffffff\r");
    check("R7 cr start count", 32'(st_cnt - s0), 32'd1);
    check("R7 cr hold", 32'(cpu_hold), 32'd0);

    finish_run();
  end
endmodule